// File: doc/BRIEF.md
# Floating Point Minimum/Maximum and Sign Unit

This unit takes two IEEE single-precision operands and returns either the smaller or the larger of them, or applies one of two sign-only operations (negate, absolute value) to the first operand. A two-bit operation code selects among the four functions. A one-bit mode input selects how NaN operands are treated. The legacy rule lets a quiet NaN propagate. The newer rule lets a single quiet NaN yield the other operand in min/max, and leaves signalling NaNs untouched by the sign-only operations.

Operands are classified (quiet NaN, signalling NaN, other) and ordered by sign and magnitude. Inputs are captured on every rising clock edge. The result and an invalid-operation flag appear on registered outputs one cycle later. The unit does no arithmetic and does not flush denormals; denormals are ordered like any other finite value.

Top module: `fp_minmax_unit`

## Requirements
- R1: While rst_n is low, result and invalid are 0. After reset, the outputs show the function of the inputs present at the previous rising clock edge.
- R2: NaN means exponent field all ones with a nonzero fraction. A NaN with fraction bit 22 set is quiet; a NaN with bit 22 clear is signalling. For min/max, if either operand is a signalling NaN, the result is that operand with bit 22 set and invalid is 1. When both operands are signalling, operand a is used. This holds in both modes.
- R3: With mode = 0 (legacy rule), no signalling NaN and at least one quiet NaN in min/max, the result is a if a is a quiet NaN, otherwise b. invalid is 0.
- R4: With mode = 1 (newer rule), no signalling NaN and exactly one quiet NaN in min/max, the result is the other operand. When both operands are quiet NaNs, the result is a. invalid is 0.
- R5: The op codes are 00 min, 01 max, 10 negate and 11 absolute value. For min/max of two non-NaN operands, negative infinity is below every value and positive infinity is above every value. With differing signs the positive operand is larger. With equal signs the larger exponent-then-fraction magnitude is larger for positive operands and smaller for negative operands. max returns the larger value, min returns the smaller, and invalid is 0.
- R6: For min/max with one operand +0 and the other -0, in either order, max returns +0 (0x00000000) and min returns -0 (0x80000000).
- R7: Negate returns a with bit 31 inverted and invalid 0. The only exception is a signalling NaN a under mode 0. Operand b has no effect.
- R8: Absolute value returns a with bit 31 cleared and invalid 0. The only exception is a signalling NaN a under mode 0. Operand b has no effect.
- R9: Under mode 0, negate and absolute value of a signalling NaN set bit 22 and raise invalid. Negate keeps the sign bit and absolute value clears it. Under mode 1 such an operand is not quieted and does not raise invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a | input | 32 | Left operand, also the operand of negate and absolute value |
| b | input | 32 | Right operand |
| op | input | 2 | Operation: 00 min, 01 max, 10 negate, 11 absolute value |
| mode | input | 1 | NaN rule: 0 legacy, 1 newer |
| result | output | 32 | Registered result |
| invalid | output | 1 | Registered invalid-operation flag |

## Verification
The hardest cases to reach are the NaN priority corners: both operands signalling, a signalling NaN on b while a is a quiet NaN, and the newer-mode case of both operands quiet. Uniform random 32-bit words almost never land on these. The stimulus therefore draws each operand from a class first (quiet NaN, signalling NaN, signed zero, infinity, finite, raw bits) and only then fills in random payload bits. Every class pairing then occurs many times under both modes. Directed vectors pin down the signed-zero ordering and the sign-only operations on signalling NaNs.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

  typedef enum logic [1:0] {
    OP_MIN = 2'b00,
    OP_MAX = 2'b01,
    OP_NEG = 2'b10,
    OP_ABS = 2'b11
  } fmm_op_e;

  // Operand class flags produced by the classifier
  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_qnan;
  } fmm_cls_t;

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
  import fmm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] x,
  output fmm_cls_t              cls
);
  localparam int QB = FRAC_W - 1;

  function automatic fmm_cls_t classify(input logic [EXP_W-1:0] e, input logic [FRAC_W-1:0] f);
    fmm_cls_t c;
    c.is_nan  = (&e) && (|f);
    c.is_qnan = c.is_nan && f[QB];
    c.is_snan = c.is_nan && !f[QB];
    return c;
  endfunction

  assign cls = classify(x[EXP_W+FRAC_W-1:FRAC_W], x[FRAC_W-1:0]);
endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] x,
  input  logic [EXP_W+FRAC_W:0] y,
  output logic                  x_lt_y
);
  localparam int W = EXP_W + FRAC_W + 1;

  // Ordering of non-NaN values: sign first, then magnitude (exponent over fraction)
  function automatic logic less_than(input logic [W-1:0] p, input logic [W-1:0] q);
    if (p[W-1] != q[W-1])
      return p[W-1];
    else if (!p[W-1])
      return p[W-2:0] < q[W-2:0];
    else
      return p[W-2:0] > q[W-2:0];
  endfunction

  assign x_lt_y = less_than(x, y);
endmodule

// File: rtl/fmm_minmax.sv
module fmm_minmax
  import fmm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  fmm_cls_t              cls_a,
  input  fmm_cls_t              cls_b,
  input  logic                  a_lt_b,
  input  logic                  b_lt_a,
  input  logic                  want_max,
  input  logic                  rule_new,
  output logic [EXP_W+FRAC_W:0] res,
  output logic                  inv,
  output logic                  ev_snan,
  output logic                  ev_qnan
);
  localparam int QB = FRAC_W - 1;

  assign ev_snan = cls_a.is_snan || cls_b.is_snan;
  assign ev_qnan = !ev_snan && (cls_a.is_qnan || cls_b.is_qnan);

  always_comb begin
    res = a;
    inv = 1'b0;
    if (ev_snan) begin
      res     = cls_a.is_snan ? a : b;
      res[QB] = 1'b1;
      inv     = 1'b1;
    end else if (ev_qnan) begin
      if (!rule_new)
        res = cls_a.is_qnan ? a : b;
      else
        res = (cls_a.is_qnan && !cls_b.is_qnan) ? b : a;
    end else if (want_max) begin
      res = a_lt_b ? b : a;
    end else begin
      res = b_lt_a ? b : a;
    end
  end
endmodule

// File: rtl/fmm_signop.sv
module fmm_signop
  import fmm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  fmm_cls_t              cls_a,
  input  logic                  do_abs,
  input  logic                  rule_new,
  output logic [EXP_W+FRAC_W:0] res,
  output logic                  inv
);
  localparam int W  = EXP_W + FRAC_W + 1;
  localparam int QB = FRAC_W - 1;

  always_comb begin
    res = a;
    inv = 1'b0;
    if (!rule_new && cls_a.is_snan) begin
      res[QB] = 1'b1;
      if (do_abs) res[W-1] = 1'b0;
      inv = 1'b1;
    end else begin
      res[W-1] = do_abs ? 1'b0 : ~a[W-1];
    end
  end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
  import fmm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  logic [1:0]            op,
  input  logic                  mode,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  invalid
);
  localparam int W  = EXP_W + FRAC_W + 1;
  localparam int QB = FRAC_W - 1;

  fmm_op_e       op_e;
  logic [W-1:0]  opnd [2];
  fmm_cls_t      cls  [2];
  logic          a_lt_b, b_lt_a;
  logic [W-1:0]  mm_res, sg_res, nxt_res;
  logic          mm_inv, sg_inv, nxt_inv;
  logic          ev_snan, ev_qnan, ev_one_qnan;

  assign op_e    = fmm_op_e'(op);
  assign opnd[0] = a;
  assign opnd[1] = b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (.x(opnd[i]), .cls(cls[i]));
  end

  fmm_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ord_ab (.x(a), .y(b), .x_lt_y(a_lt_b));
  fmm_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ord_ba (.x(b), .y(a), .x_lt_y(b_lt_a));

  fmm_minmax #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mm (
    .a(a), .b(b), .cls_a(cls[0]), .cls_b(cls[1]),
    .a_lt_b(a_lt_b), .b_lt_a(b_lt_a),
    .want_max(op_e == OP_MAX), .rule_new(mode),
    .res(mm_res), .inv(mm_inv), .ev_snan(ev_snan), .ev_qnan(ev_qnan)
  );

  fmm_signop #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sg (
    .a(a), .cls_a(cls[0]), .do_abs(op_e == OP_ABS), .rule_new(mode),
    .res(sg_res), .inv(sg_inv)
  );

  assign nxt_res     = op[1] ? sg_res : mm_res;
  assign nxt_inv     = op[1] ? sg_inv : mm_inv;
  assign ev_one_qnan = ev_qnan && (cls[0].is_qnan != cls[1].is_qnan);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      invalid <= 1'b0;
    end else begin
      result  <= nxt_res;
      invalid <= nxt_inv;
    end
  end

  // R2
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> ((&result[W-2:FRAC_W]) && result[QB]));

  // R4
  one_qnan_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!op[1] && mode && ev_one_qnan))
      |-> !((&result[W-2:FRAC_W]) && (|result[FRAC_W-1:0])));

  // R5
  pick_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!op[1] && !ev_snan && !ev_qnan))
      |-> ((result == $past(a)) || (result == $past(b))) && !invalid);

  // R7
  neg_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_e == OP_NEG && mode))
      |-> (result == {~$past(a[W-1]), $past(a[W-2:0])}));

  // R8
  abs_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_e == OP_ABS)) |-> !result[W-1]);

  // R9
  sign_new_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op[1] && mode)) |-> !invalid);

endmodule

// File: tb/fp_minmax_unit_test.sv
module fp_minmax_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [1:0]  op = '0;
  logic        mode = 1'b0;
  logic [31:0] result;
  logic        invalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fp_minmax_unit uut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .mode(mode),
    .result(result), .invalid(invalid)
  );

  localparam logic [31:0] QBIT = 32'h0040_0000;
  localparam logic [31:0] SBIT = 32'h8000_0000;

  function automatic bit f_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction
  function automatic bit f_snan(input logic [31:0] x);
    return f_nan(x) && (x[22] == 1'b0);
  endfunction
  function automatic bit f_qnan(input logic [31:0] x);
    return f_nan(x) && x[22];
  endfunction
  // Monotone integer key for non-NaN values
  function automatic logic [31:0] f_key(input logic [31:0] x);
    return x[31] ? ~x : (x | SBIT);
  endfunction

  // Returns {invalid, result}
  function automatic logic [32:0] f_model(input logic [31:0] x, input logic [31:0] y,
                                          input logic [1:0] o, input logic m);
    logic [31:0] r;
    logic        iv;
    iv = 1'b0;
    if (o == 2'b10) begin
      if (!m && f_snan(x)) begin r = x | QBIT; iv = 1'b1; end
      else r = x ^ SBIT;
    end else if (o == 2'b11) begin
      if (!m && f_snan(x)) begin r = (x | QBIT) & ~SBIT; iv = 1'b1; end
      else r = x & ~SBIT;
    end else if (f_snan(x) || f_snan(y)) begin
      r  = (f_snan(x) ? x : y) | QBIT;
      iv = 1'b1;
    end else if (f_qnan(x) || f_qnan(y)) begin
      if (!m) r = f_qnan(x) ? x : y;
      else if (f_qnan(x) && f_qnan(y)) r = x;
      else r = f_qnan(x) ? y : x;
    end else if (o == 2'b01) begin
      r = (f_key(x) >= f_key(y)) ? x : y;
    end else begin
      r = (f_key(x) <= f_key(y)) ? x : y;
    end
    return {iv, r};
  endfunction

  function automatic string f_tag(input logic [31:0] x, input logic [31:0] y,
                                  input logic [1:0] o, input logic m);
    if (o[1]) begin
      if (!m && f_snan(x)) return "R9";
      return (o == 2'b10) ? "R7" : "R8";
    end
    if (f_snan(x) || f_snan(y)) return "R2";
    if (f_qnan(x) || f_qnan(y)) return m ? "R4" : "R3";
    if ((x[30:0] == 31'd0) && (y[30:0] == 31'd0)) return "R6";
    return "R5";
  endfunction

  task automatic run(input logic [31:0] x, input logic [31:0] y,
                     input logic [1:0] o, input logic m);
    logic [32:0] exp_v;
    string tag;
    @(negedge clk);
    a = x; b = y; op = o; mode = m;
    exp_v = f_model(x, y, o, m);
    tag = f_tag(x, y, o, m);
    @(negedge clk);
    checks++;
    if ({invalid, result} !== exp_v) begin
      fails++;
      $display("FAIL %s a=%h b=%h op=%0d mode=%0d: got inv=%0b res=%h, expected inv=%0b res=%h",
               tag, x, y, o, m, invalid, result, exp_v[32], exp_v[31:0]);
    end
  endtask

  function automatic logic [31:0] f_rand_opnd();
    logic        s;
    logic [22:0] fr;
    s  = 1'($urandom());
    fr = 23'($urandom());
    case ($urandom() % 8)
      0, 1: return $urandom();
      2:    return {s, 31'd0};
      3:    return {s, 8'hFF, 23'd0};
      4:    return {s, 8'hFF, 1'b1, fr[21:0]};
      5:    return {s, 8'hFF, 1'b0, fr[21:1], 1'b1};
      default: return {s, 8'($urandom() % 255), fr};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24601));
    a = 32'h3F80_0000; b = 32'h4000_0000; op = 2'b01; mode = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 32'd0 || invalid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got res=%h inv=%0b, expected res=00000000 inv=0", result, invalid);
    end
    rst_n = 1'b1;

    // R1 / R5: latency and basic ordering
    run(32'h3F80_0000, 32'h4000_0000, 2'b01, 1'b0);
    run(32'h3F80_0000, 32'h4000_0000, 2'b00, 1'b1);
    run(32'hBF80_0000, 32'hC000_0000, 2'b00, 1'b0);
    run(32'hFF80_0000, 32'hFF7F_FFFF, 2'b00, 1'b0);
    run(32'h7F80_0000, 32'h7F7F_FFFF, 2'b01, 1'b1);
    run(32'h0000_0001, 32'h8000_0001, 2'b00, 1'b0);
    // R6: signed zeros both orders
    run(32'h0000_0000, 32'h8000_0000, 2'b01, 1'b0);
    run(32'h8000_0000, 32'h0000_0000, 2'b01, 1'b1);
    run(32'h0000_0000, 32'h8000_0000, 2'b00, 1'b0);
    run(32'h8000_0000, 32'h0000_0000, 2'b00, 1'b1);
    // R2: signalling NaN priority
    run(32'h7F80_0001, 32'h7F80_0002, 2'b00, 1'b1);
    run(32'h7FC0_0005, 32'hFF80_0003, 2'b01, 1'b0);
    run(32'h3F80_0000, 32'h7F80_0010, 2'b01, 1'b1);
    // R3 / R4: quiet NaN rules
    run(32'h3F80_0000, 32'h7FC0_0000, 2'b00, 1'b0);
    run(32'h3F80_0000, 32'h7FC0_0000, 2'b00, 1'b1);
    run(32'hFFC0_0001, 32'h4000_0000, 2'b01, 1'b1);
    run(32'h7FC0_0001, 32'hFFC0_0002, 2'b01, 1'b1);
    run(32'h7FC0_0001, 32'hFFC0_0002, 2'b01, 1'b0);
    // R7 / R8 / R9: sign-only operations
    run(32'h3F80_0000, 32'h7F80_0001, 2'b10, 1'b0);
    run(32'h8000_0000, 32'hFFFF_FFFF, 2'b11, 1'b0);
    run(32'hFF80_0001, 32'h0, 2'b10, 1'b0);
    run(32'hFF80_0001, 32'h0, 2'b11, 1'b0);
    run(32'hFF80_0001, 32'h0, 2'b10, 1'b1);
    run(32'hFF80_0001, 32'h0, 2'b11, 1'b1);
    run(32'h7FC0_0000, 32'h0, 2'b10, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] x, y;
      x = f_rand_opnd();
      y = (($urandom() % 6) == 0) ? x ^ SBIT : f_rand_opnd();
      run(x, y, 2'($urandom()), 1'($urandom()));
    end

    // R1: reset clears outputs again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    checks++;
    if (result !== 32'd0 || invalid !== 1'b0) begin
      fails++;
      $display("FAIL R1 re-reset: got res=%h inv=%0b, expected res=00000000 inv=0", result, invalid);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule